// File: doc/BRIEF.md
# Indexed Configuration Base-Address Decoder

This block is a two-entry configuration store that the host reaches through an index/data register pair, together with two chip-select decoders driven by it. The host first writes an index value through the index port. It then reads or writes the selected register through the data port. Index 23H holds the parallel-port base and index 24H holds the serial-port base. No other index is stored.

Each decoder compares the host address against its base register and raises a select for its peripheral. The parallel decoder changes its granularity with the port mode. In compatible and bidirectional modes it resolves 4-byte windows. In EPP mode it resolves 8-byte windows. In ECP mode it also answers in the mirror window 400H above the base, and a separate output flags that upper window. Both decoders are gated by an active-low chip select and by address bit 10. A base whose top two bits are zero switches its decoder off. The reset contents come from a strap input sampled while reset is held.

Top module: `cfg_base_decoder`

## Requirements
- R1: When the data port is written, the value goes to the register named by the index register: 23H is the parallel base and 24H is the serial base. A data-port read returns that register. An index-port read returns the index last written.
- R2: A reset taken with `cfg_strap` = 1 loads DEH into the parallel base and FEH into the serial base, and clears the index register to 00H.
- R3: A reset taken with `cfg_strap` = 0 loads 00H into both bases.
- R4: In compatible mode (`pp_mode` = 0) and bidirectional mode (`pp_mode` = 1), `pp_sel` asserts exactly when address bits 9:2 equal the parallel base and bit 10 is 0.
- R5: In EPP mode (`pp_mode` = 2), base bit 0 and address bit 2 take no part in the compare. `pp_sel` asserts when address bits 9:3 equal base bits 7:1 and bit 10 is 0.
- R6: `sp_sel` asserts exactly when address bits 9:3 equal serial base bits 7:1 and bit 10 is 0. Address bits 2:0 have no effect.
- R7: Bit 0 of the serial base always reads 0, whatever value is written to it.
- R8: A base with bits 7:6 both zero disables its decoder, and its select never asserts.
- R9: While `host_cs_n` is 1, no select asserts. Address bit 10 = 1 blocks `sp_sel` always, and blocks `pp_sel` in every mode except ECP.
- R10: In ECP mode (`pp_mode` = 3), `pp_sel` asserts when address bits 9:2 equal the base, whatever the value of bit 10. `pp_ecp_hi` is 1 exactly when `pp_sel` is 1 and bit 10 is 1, and it is 0 in every other mode.
- R11: A data-port access with any index other than 23H or 24H reads 00H, and a write at such an index leaves both bases unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_strap | input | 1 | Strap that selects the reset defaults |
| cfg_wr | input | 1 | Write strobe for the index/data pair |
| cfg_sel_data | input | 1 | 0 selects the index port, 1 selects the data port |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for the selected port |
| host_cs_n | input | 1 | Active-low global chip select |
| host_addr | input | 11 | Host address bits 10:0 |
| pp_mode | input | 2 | Parallel-port mode: 0 compatible, 1 bidirectional, 2 EPP, 3 ECP |
| pp_sel | output | 1 | Parallel-port select |
| pp_ecp_hi | output | 1 | Parallel select hit the upper ECP window |
| sp_sel | output | 1 | Serial-port select |

## Verification
The bench builds the block with its default 8-bit register width, which gives an 11-bit address space. At that size every address from 000H to 7FFH can be swept for each pair of base values in each of the four parallel modes, with the chip select both low and high. Exhaustive sweeps expose the window edges, the EPP rounding of odd bases, the ECP mirror and the disable encoding directly. The reset defaults are checked under both strap values.

// File: rtl/cfg_dec_pkg.sv
// Package: shared types for the configuration base-address decoder.
// Assumes nothing beyond a 2-bit mode field from the host side.
package cfg_dec_pkg;
    typedef enum logic [1:0] {
        PM_COMPAT = 2'd0,
        PM_BIDIR  = 2'd1,
        PM_EPP    = 2'd2,
        PM_ECP    = 2'd3
    } pp_mode_t;
endpackage

// File: rtl/cfg_regfile.sv
// Module: cfg_regfile
// Holds the index register and the two base registers behind an
// index/data pair. Writes land on the rising clock edge. Reads are
// combinational. The strap is sampled only while reset is held.
module cfg_regfile #(
    parameter int          REG_W     = 8,
    parameter logic [7:0]  IDX_PP    = 8'h23,
    parameter logic [7:0]  IDX_SP    = 8'h24,
    parameter logic [REG_W-1:0] PP_DEF = 8'hDE,
    parameter logic [REG_W-1:0] SP_DEF = 8'hFE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_strap,
    input  logic             cfg_wr,
    input  logic             cfg_sel_data,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    output logic [REG_W-1:0] pp_base,
    output logic [REG_W-1:0] sp_base
);
    logic [REG_W-1:0] idx_q;
    logic [REG_W-1:0] pp_q;
    logic [REG_W-1:1] sp_q;
    logic [REG_W-1:0] data_rd;

    // Register update: strap-dependent defaults on reset, else host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            pp_q  <= cfg_strap ? PP_DEF : '0;
            sp_q  <= cfg_strap ? SP_DEF[REG_W-1:1] : '0;
        end else if (cfg_wr) begin
            if (!cfg_sel_data)
                idx_q <= cfg_wdata;
            else if (idx_q == IDX_PP[REG_W-1:0])
                pp_q <= cfg_wdata;
            else if (idx_q == IDX_SP[REG_W-1:0])
                sp_q <= cfg_wdata[REG_W-1:1];
        end
    end

    // Data-port read mux: unknown indices read zero.
    always_comb begin
        if (idx_q == IDX_PP[REG_W-1:0])
            data_rd = pp_q;
        else if (idx_q == IDX_SP[REG_W-1:0])
            data_rd = {sp_q, 1'b0};
        else
            data_rd = '0;
    end

    assign cfg_rdata = cfg_sel_data ? data_rd : idx_q;
    assign pp_base   = pp_q;
    assign sp_base   = {sp_q, 1'b0};

    // R7: a serial-base write keeps bit 0 at zero
    assert_sp_bit0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel_data && idx_q == IDX_SP[REG_W-1:0])
        |=> (cfg_rdata[0] == 1'b0 || !cfg_sel_data) && sp_base == {$past(cfg_wdata[REG_W-1:1]), 1'b0});

    // R11: data writes at a foreign index leave the parallel base alone
    assert_pp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel_data && idx_q != IDX_PP[REG_W-1:0]) |=> $stable(pp_base));

    // R2: defaults follow the strap seen during reset
    assert_reset_default_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pp_base == ($past(cfg_strap) ? PP_DEF : '0)));
endmodule

// File: rtl/pp_decoder.sv
// Module: pp_decoder
// Combinational parallel-port select. The granularity depends on the
// mode: 4 bytes normally, 8 bytes in EPP. ECP mode also answers in
// the mirror window with the top address bit set. Assumes the address
// is REG_W+3 bits wide and the base register is REG_W bits wide.
module pp_decoder
    import cfg_dec_pkg::*;
#(
    parameter int REG_W  = 8,
    localparam int ADDR_W = REG_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  base,
    input  pp_mode_t          mode,
    input  logic              cs_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              sel,
    output logic              ecp_hi
);
    logic [REG_W-1:0] field;
    logic             a_top;
    logic             enabled;
    logic             hit;

    assign field   = addr[ADDR_W-2:2];
    assign a_top   = addr[ADDR_W-1];
    assign enabled = |base[REG_W-1:REG_W-2];

    // Mode-dependent window compare.
    always_comb begin
        case (mode)
            PM_ECP:  hit = (field == base);
            PM_EPP:  hit = (field[REG_W-1:1] == base[REG_W-1:1]) && !a_top;
            default: hit = (field == base) && !a_top;
        endcase
    end

    assign sel    = !cs_n && enabled && hit;
    assign ecp_hi = sel && a_top;

    // R8: disabled base never selects
    assert_pp_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (base[REG_W-1:REG_W-2] == 2'b00) |-> !sel);

    // R10: upper-window flag only in ECP mode
    assert_ecp_hi_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ecp_hi |-> (mode == PM_ECP && sel));

    // R9: top address bit blocks outside ECP
    assert_pp_top_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (a_top && mode != PM_ECP) |-> !sel);
endmodule

// File: rtl/sp_decoder.sv
// Module: sp_decoder
// Combinational serial-port select on 8-byte windows. Assumes base
// bit 0 is unused and the address is REG_W+3 bits wide.
module sp_decoder #(
    parameter int REG_W  = 8,
    localparam int ADDR_W = REG_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  base,
    input  logic              cs_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              sel
);
    logic enabled;
    logic hit;

    assign enabled = |base[REG_W-1:REG_W-2];
    assign hit     = (addr[ADDR_W-2:3] == base[REG_W-1:1]) && !addr[ADDR_W-1];
    assign sel     = !cs_n && enabled && hit;

    // R9: top address bit always blocks the serial select
    assert_sp_top_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        addr[ADDR_W-1] |-> !sel);

    // R8: disabled serial base never selects
    assert_sp_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (base[REG_W-1:REG_W-2] == 2'b00) |-> !sel);
endmodule

// File: rtl/cfg_base_decoder.sv
// Module: cfg_base_decoder
// Top level: index/data configuration store feeding the parallel and
// serial chip-select decoders. Assumes the host has already entered
// configuration mode whenever it drives cfg_wr.
module cfg_base_decoder
    import cfg_dec_pkg::*;
#(
    parameter int REG_W  = 8,
    localparam int ADDR_W = REG_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_strap,
    input  logic              cfg_wr,
    input  logic              cfg_sel_data,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              host_cs_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [1:0]        pp_mode,
    output logic              pp_sel,
    output logic              pp_ecp_hi,
    output logic              sp_sel
);
    logic [REG_W-1:0] pp_base;
    logic [REG_W-1:0] sp_base;
    pp_mode_t         mode_e;

    assign mode_e = pp_mode_t'(pp_mode);

    cfg_regfile #(.REG_W(REG_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_strap    (cfg_strap),
        .cfg_wr       (cfg_wr),
        .cfg_sel_data (cfg_sel_data),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .pp_base      (pp_base),
        .sp_base      (sp_base)
    );

    pp_decoder #(.REG_W(REG_W)) u_pp (
        .clk    (clk),
        .rst_n  (rst_n),
        .base   (pp_base),
        .mode   (mode_e),
        .cs_n   (host_cs_n),
        .addr   (host_addr),
        .sel    (pp_sel),
        .ecp_hi (pp_ecp_hi)
    );

    sp_decoder #(.REG_W(REG_W)) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .base  (sp_base),
        .cs_n  (host_cs_n),
        .addr  (host_addr),
        .sel   (sp_sel)
    );

    // R9: chip select high silences both decoders
    assert_cs_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_cs_n |-> (!pp_sel && !sp_sel && !pp_ecp_hi));
endmodule

// File: tb/cfg_base_decoder_test.sv
module cfg_base_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_strap = 1'b1;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel_data = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        host_cs_n = 1'b1;
    logic [10:0] host_addr = '0;
    logic [1:0]  pp_mode = 2'd0;
    logic        pp_sel, pp_ecp_hi, sp_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cfg_base_decoder uut (
        .clk(clk), .rst_n(rst_n), .cfg_strap(cfg_strap), .cfg_wr(cfg_wr),
        .cfg_sel_data(cfg_sel_data), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .host_cs_n(host_cs_n), .host_addr(host_addr), .pp_mode(pp_mode),
        .pp_sel(pp_sel), .pp_ecp_hi(pp_ecp_hi), .sp_sel(sp_sel)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input bit strap);
        @(negedge clk);
        rst_n = 1'b0; cfg_strap = strap; cfg_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input bit data_port, input logic [7:0] v);
        @(negedge clk);
        cfg_sel_data = data_port; cfg_wdata = v; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input bit data_port, output logic [7:0] v);
        @(negedge clk);
        cfg_sel_data = data_port;
        #1 v = cfg_rdata;
    endtask

    function automatic bit exp_pp(input int mode, input int b, input int a, input bit cs_n);
        int top = a / 1024;
        int low = a % 1024;
        if (cs_n || b < 64) return 1'b0;
        if (mode == 3) return (low / 4) == b;
        if (top != 0) return 1'b0;
        if (mode == 2) return (low / 8) == (b / 2);
        return (low / 4) == b;
    endfunction

    function automatic bit exp_sp(input int b, input int a, input bit cs_n);
        if (cs_n || b < 64 || a >= 1024) return 1'b0;
        return (a / 8) == (b / 2);
    endfunction

    task automatic set_bases(input logic [7:0] pb, input logic [7:0] sb);
        wr(1'b0, 8'h23); wr(1'b1, pb);
        wr(1'b0, 8'h24); wr(1'b1, sb);
    endtask

    task automatic sweep(input int pb, input int sb);
        for (int m = 0; m < 4; m++) begin
            for (int c = 0; c < 2; c++) begin
                pp_mode = 2'(m);
                host_cs_n = 1'(c);
                for (int a = 0; a < 2048; a++) begin
                    host_addr = 11'(a);
                    #1;
                    if (c == 1) begin
                        check("R9", int'(pp_sel) + int'(sp_sel), 0, "cs high");
                    end else begin
                        check(m == 2 ? "R5" : (m == 3 ? "R10" : "R4"), int'(pp_sel),
                              int'(exp_pp(m, pb, a, 1'b0)), $sformatf("pp m%0d b%0h a%0h", m, pb, a));
                        check("R10", int'(pp_ecp_hi),
                              int'(exp_pp(m, pb, a, 1'b0) && m == 3 && a >= 1024), "ecp_hi");
                        check("R6", int'(sp_sel), int'(exp_sp(sb, a, 1'b0)),
                              $sformatf("sp b%0h a%0h", sb, a));
                    end
                end
            end
        end
        host_cs_n = 1'b1;
    endtask

    initial begin
        logic [7:0] v;
        // R2: strap high defaults
        do_reset(1'b1);
        rd(1'b0, v); check("R2", int'(v), 8'h00, "index after reset");
        wr(1'b0, 8'h23); rd(1'b1, v); check("R2", int'(v), 8'hDE, "pp default");
        wr(1'b0, 8'h24); rd(1'b1, v); check("R2", int'(v), 8'hFE, "sp default");
        sweep(8'hDE, 8'hFE);
        // R3: strap low defaults and disabled decode
        do_reset(1'b0);
        wr(1'b0, 8'h23); rd(1'b1, v); check("R3", int'(v), 8'h00, "pp default");
        wr(1'b0, 8'h24); rd(1'b1, v); check("R3", int'(v), 8'h00, "sp default");
        sweep(0, 0);
        // R1: write and read back through the pair
        set_bases(8'h9F, 8'h7A);
        rd(1'b0, v); check("R1", int'(v), 8'h24, "index readback");
        rd(1'b1, v); check("R1", int'(v), 8'h7A, "sp readback");
        wr(1'b0, 8'h23); rd(1'b1, v); check("R1", int'(v), 8'h9F, "pp readback");
        // R7: serial bit 0 write is dropped
        wr(1'b0, 8'h24); wr(1'b1, 8'hC3); rd(1'b1, v); check("R7", int'(v), 8'hC2, "sp bit0");
        // R11: foreign index reads zero, write has no effect
        wr(1'b0, 8'h25); wr(1'b1, 8'h55); rd(1'b1, v); check("R11", int'(v), 8'h00, "foreign read");
        wr(1'b0, 8'h23); rd(1'b1, v); check("R11", int'(v), 8'h9F, "pp untouched");
        wr(1'b0, 8'h24); rd(1'b1, v); check("R11", int'(v), 8'hC2, "sp untouched");
        sweep(8'h9F, 8'hC3);
        // R8: top bits zero disable, boundary bases
        set_bases(8'h3F, 8'h3E); sweep(8'h3F, 8'h3E);
        set_bases(8'h40, 8'hFF); sweep(8'h40, 8'hFE);
        set_bases(8'hFF, 8'h40); sweep(8'hFF, 8'h40);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule